// File: doc/BRIEF.md
# Packet-to-register transaction converter

This block sits behind a byte-level packet decoder and turns each request packet into 32-bit register accesses on a simple memory-mapped master port. A request opens with an eight-byte header: the operation code is first, then one spare byte, then a 16-bit byte count and a 32-bit start address, both most-significant byte first. Write requests carry their data words after the header. Read requests end with the header. The block runs one access per word. In sequential mode it steps the address by one word each time. It then sends a response packet on a second byte stream.

A read returns only the data words, each sent low byte first. A write, or a request the block does not recognise, returns a four-byte status record. The input and output streams each carry a last-byte flag to mark packet boundaries. The block handles one packet at a time and does not accept new input while it is accessing the bus or sending a response.

Top module: `pkt_reg_xactor`

## Requirements
- R1: The header is read as: byte 0 the operation code, byte 1 ignored, bytes 2..3 the byte count with the high byte first, bytes 4..7 the start address with the high byte first. The first bus access of a request uses that address.
- R2: Code 0x00 (single) and code 0x04 (sequential) are writes. Code 0x10 (single) and code 0x14 (sequential) are reads.
- R3: Write data follows the header, four bytes per word. The first byte of a word goes to bits 7:0. Each complete word that ends at or before the header byte count is issued as one bus write.
- R4: Each further word of a request is accessed at the previous address plus 4.
- R5: A write request is answered with four bytes: the request code OR 0x80, then 0x00, then the accepted byte count high byte, then its low byte. The last flag is set on the fourth byte only.
- R6: The accepted byte count is the header count only when the number of data bytes received equals it and it is a multiple of 4. Otherwise the count reported is 0. Words beyond the header count are not written.
- R7: A read request returns count/4 words with no header. A count below 4 reads one word, and a count above 1024 reads 256 words. Each word is sent low byte first, with the last flag only on the final byte.
- R8: Code 0x7F, any other unlisted code, or a packet that ends before its eighth header byte, makes no bus access and is answered with the bytes FF 00 00 00.
- R9: A bus read or write stays asserted with a stable address (and stable write data) while waitrequest is high. Read and write are never asserted together.
- R10: During reset, read, write and the output valid are low and the input ready is high.
- R11: While output valid is high and output ready is low, the output byte and last flag hold.
- R12: Bytes that follow a read header, up to the end of the packet, are accepted and change neither the words read nor their addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request byte valid |
| inReady | output | 1 | Request byte accepted when high with inValid |
| inData | input | 8 | Request byte |
| inLast | input | 1 | Final byte of the request packet |
| outValid | output | 1 | Response byte valid |
| outReady | input | 1 | Downstream takes the response byte |
| outData | output | 8 | Response byte |
| outLast | output | 1 | Final byte of the response packet |
| busAddr | output | 32 | Master port byte address |
| busWrData | output | 32 | Master port write data |
| busRdData | input | 32 | Master port read data, valid when a read completes |
| busRead | output | 1 | Read strobe |
| busWrite | output | 1 | Write strobe |
| busWait | input | 1 | Slave stall; an access completes in a cycle where it is low |

## Verification
The bench runs matched single and sequential writes, each followed by a read of the same location. This shows whether the header address, the little-endian word packing and the per-word address step agree from both sides. Write packets are also sent with too many, too few and non-aligned data bytes. These separate the rule for which words get written from the rule for the reported count. Reads with a zero count, an oversized count and trailing junk bytes exercise the word-count clamp and the input drain. Unknown codes, the no-transaction code, and headers cut short after one and five bytes must all produce the fixed error record without touching the bus. Random stalls on waitrequest and output ready run throughout.

// File: rtl/pkt_reg_pkg.sv
package pkt_reg_pkg;

  localparam logic [7:0] CODE_WR     = 8'h00;
  localparam logic [7:0] CODE_WR_SEQ = 8'h04;
  localparam logic [7:0] CODE_RD     = 8'h10;
  localparam logic [7:0] CODE_RD_SEQ = 8'h14;
  localparam logic [7:0] CODE_NONE   = 8'h7F;
  localparam logic [7:0] RESP_FLAG   = 8'h80;
  localparam logic [7:0] RESP_BAD    = 8'hFF;

  typedef enum logic [1:0] {KIND_WRITE, KIND_READ, KIND_BAD} kind_e;
  typedef enum logic [1:0] {OSEL_NONE, OSEL_RESP, OSEL_RDATA} osel_e;

  // control -> datapath
  typedef struct packed {
    logic  byteClr;
    logic  byteInc;
    logic  hdrLoad;
    logic  codeBad;
    logic  dataLoad;
    logic  addrInc;
    logic  rdCapture;
    logic  wordDec;
    osel_e outSel;
  } strobes_t;

  // datapath -> control
  typedef struct packed {
    logic  hdrDone;
    logic  laneDone;
    logic  wordFits;
    logic  wordsLast;
    kind_e kind;
  } status_t;

endpackage

// File: rtl/pkt_reg_dpath.sv
module pkt_reg_dpath
  import pkt_reg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int MAX_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        inData,
  input  logic [DATA_W-1:0] busRdData,
  input  strobes_t          strobes,
  output status_t           status,
  output logic [7:0]        outData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData
);

  localparam int LANES    = DATA_W / 8;
  localparam int LANE_W   = $clog2(LANES);
  localparam int HDR_LEN  = 8;
  localparam int IDX_W    = $clog2(HDR_LEN);
  localparam int WCNT_W   = $clog2(MAX_WORDS + 1);
  localparam int SWORDS_W = CNT_W - LANE_W;

  logic [IDX_W-1:0]    byteIdx;
  logic [7:0]          codeQ;
  logic [CNT_W-1:0]    sizeQ;
  logic [ADDR_W-1:0]   addrQ;
  logic [CNT_W:0]      dataBytes;
  logic [WCNT_W-1:0]   wordsLeft;
  logic [DATA_W-1:0]   wrWord;
  logic [DATA_W-1:0]   rdWord;

  logic [LANE_W-1:0]   lane;
  logic [SWORDS_W-1:0] sizeWords;
  logic [WCNT_W-1:0]   wordsInit;
  logic                countOk;
  logic [CNT_W-1:0]    respCount;
  logic [7:0]          respByte;
  logic [7:0]          rdByte;

  assign lane      = byteIdx[LANE_W-1:0];
  assign sizeWords = sizeQ[CNT_W-1:LANE_W];

  // word count for reads: zero -> one word, clamp at MAX_WORDS
  always_comb begin
    if (sizeWords == '0)
      wordsInit = WCNT_W'(1);
    else if (sizeWords > SWORDS_W'(MAX_WORDS))
      wordsInit = WCNT_W'(MAX_WORDS);
    else
      wordsInit = WCNT_W'(sizeWords);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteIdx   <= '0;
      codeQ     <= '0;
      sizeQ     <= '0;
      addrQ     <= '0;
      dataBytes <= '0;
      wordsLeft <= '0;
      wrWord    <= '0;
      rdWord    <= '0;
    end else begin
      if (strobes.byteClr)
        byteIdx <= '0;
      else if (strobes.byteInc)
        byteIdx <= byteIdx + 1'b1;

      if (strobes.codeBad)
        codeQ <= CODE_NONE;
      else if (strobes.hdrLoad && byteIdx == IDX_W'(0))
        codeQ <= inData;

      if (strobes.hdrLoad && !strobes.codeBad) begin
        case (byteIdx)
          IDX_W'(2): sizeQ[15:8]   <= inData;
          IDX_W'(3): sizeQ[7:0]    <= inData;
          IDX_W'(4): addrQ[31:24]  <= inData;
          IDX_W'(5): addrQ[23:16]  <= inData;
          IDX_W'(6): addrQ[15:8]   <= inData;
          IDX_W'(7): begin
            addrQ[7:0] <= inData;
            dataBytes  <= '0;
            wordsLeft  <= wordsInit;
          end
          default: ;
        endcase
      end

      if (strobes.addrInc)
        addrQ <= addrQ + ADDR_W'(LANES);

      if (strobes.dataLoad) begin
        wrWord[{lane, 3'b000} +: 8] <= inData;
        dataBytes <= dataBytes + 1'b1;
      end

      if (strobes.rdCapture)
        rdWord <= busRdData;

      if (strobes.wordDec)
        wordsLeft <= wordsLeft - 1'b1;
    end
  end

  always_comb begin
    case (codeQ)
      CODE_WR, CODE_WR_SEQ: status.kind = KIND_WRITE;
      CODE_RD, CODE_RD_SEQ: status.kind = KIND_READ;
      default:              status.kind = KIND_BAD;
    endcase
  end

  assign status.hdrDone   = (byteIdx == IDX_W'(HDR_LEN - 1));
  assign status.laneDone  = (lane == LANE_W'(LANES - 1));
  assign status.wordFits  = ((dataBytes + 1'b1) <= {1'b0, sizeQ});
  assign status.wordsLast = (wordsLeft == WCNT_W'(1));

  assign countOk   = (dataBytes == {1'b0, sizeQ}) && (sizeQ[LANE_W-1:0] == '0);
  assign respCount = (status.kind == KIND_WRITE && countOk) ? sizeQ : '0;

  always_comb begin
    case (lane)
      LANE_W'(0): respByte = (status.kind == KIND_BAD) ? RESP_BAD : (codeQ | RESP_FLAG);
      LANE_W'(1): respByte = 8'h00;
      LANE_W'(2): respByte = respCount[15:8];
      default:    respByte = respCount[7:0];
    endcase
  end

  assign rdByte = rdWord[{lane, 3'b000} +: 8];

  always_comb begin
    case (strobes.outSel)
      OSEL_RESP:  outData = respByte;
      OSEL_RDATA: outData = rdByte;
      default:    outData = 8'h00;
    endcase
  end

  assign busAddr   = addrQ;
  assign busWrData = wrWord;

endmodule

// File: rtl/pkt_reg_ctrl.sv
module pkt_reg_ctrl
  import pkt_reg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inLast,
  input  logic     outReady,
  input  logic     busWait,
  input  status_t  status,
  output logic     inReady,
  output logic     outValid,
  output logic     outLast,
  output logic     busRead,
  output logic     busWrite,
  output strobes_t strobes
);

  typedef enum logic [2:0] {
    S_HDR, S_DRAIN, S_WDATA, S_WBUS, S_RBUS, S_ROUT, S_RESP
  } state_e;

  state_e state, nextState;
  logic   pktEnded, nextEnded;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_HDR;
      pktEnded <= 1'b0;
    end else begin
      state    <= nextState;
      pktEnded <= nextEnded;
    end
  end

  always_comb begin
    strobes   = '0;
    strobes.outSel = OSEL_NONE;
    nextState = state;
    nextEnded = pktEnded;
    inReady   = 1'b0;
    outValid  = 1'b0;
    outLast   = 1'b0;
    busRead   = 1'b0;
    busWrite  = 1'b0;

    case (state)
      S_HDR: begin
        inReady = 1'b1;
        if (inValid) begin
          strobes.hdrLoad = 1'b1;
          if (inLast && !status.hdrDone) begin
            strobes.codeBad = 1'b1;
            strobes.byteClr = 1'b1;
            nextState = S_RESP;
          end else begin
            strobes.byteInc = 1'b1;
            if (status.hdrDone) begin
              case (status.kind)
                KIND_WRITE: nextState = inLast ? S_RESP : S_WDATA;
                KIND_READ:  nextState = inLast ? S_RBUS : S_DRAIN;
                default:    nextState = inLast ? S_RESP : S_DRAIN;
              endcase
            end
          end
        end
      end

      S_DRAIN: begin
        inReady = 1'b1;
        if (inValid && inLast) begin
          strobes.byteClr = 1'b1;
          nextState = (status.kind == KIND_READ) ? S_RBUS : S_RESP;
        end
      end

      S_WDATA: begin
        inReady = 1'b1;
        if (inValid) begin
          strobes.dataLoad = 1'b1;
          strobes.byteInc  = 1'b1;
          nextEnded = inLast;
          if (status.laneDone && status.wordFits) begin
            nextState = S_WBUS;
          end else if (inLast) begin
            strobes.byteClr = 1'b1;
            nextState = S_RESP;
          end
        end
      end

      S_WBUS: begin
        busWrite = 1'b1;
        if (!busWait) begin
          strobes.addrInc = 1'b1;
          if (pktEnded) begin
            strobes.byteClr = 1'b1;
            nextState = S_RESP;
          end else begin
            nextState = S_WDATA;
          end
        end
      end

      S_RBUS: begin
        busRead = 1'b1;
        if (!busWait) begin
          strobes.rdCapture = 1'b1;
          strobes.byteClr   = 1'b1;
          nextState = S_ROUT;
        end
      end

      S_ROUT: begin
        outValid = 1'b1;
        strobes.outSel = OSEL_RDATA;
        outLast  = status.laneDone && status.wordsLast;
        if (outReady) begin
          strobes.byteInc = 1'b1;
          if (status.laneDone) begin
            strobes.wordDec = 1'b1;
            if (status.wordsLast) begin
              strobes.byteClr = 1'b1;
              nextState = S_HDR;
            end else begin
              strobes.addrInc = 1'b1;
              nextState = S_RBUS;
            end
          end
        end
      end

      S_RESP: begin
        outValid = 1'b1;
        strobes.outSel = OSEL_RESP;
        outLast  = status.laneDone;
        if (outReady && status.laneDone) begin
          strobes.byteClr = 1'b1;
          nextState = S_HDR;
        end else if (outReady) begin
          strobes.byteInc = 1'b1;
        end
      end

      default: nextState = S_HDR;
    endcase
  end

endmodule

// File: rtl/pkt_reg_xactor.sv
module pkt_reg_xactor
  import pkt_reg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int MAX_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  input  logic              inLast,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              outLast,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] busRdData,
  output logic              busRead,
  output logic              busWrite,
  input  logic              busWait
);

  strobes_t strobes;
  status_t  status;

  pkt_reg_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .outReady (outReady),
    .busWait  (busWait),
    .status   (status),
    .inReady  (inReady),
    .outValid (outValid),
    .outLast  (outLast),
    .busRead  (busRead),
    .busWrite (busWrite),
    .strobes  (strobes)
  );

  pkt_reg_dpath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .MAX_WORDS (MAX_WORDS)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .inData    (inData),
    .busRdData (busRdData),
    .strobes   (strobes),
    .status    (status),
    .outData   (outData),
    .busAddr   (busAddr),
    .busWrData (busWrData)
  );

endmodule

// File: rtl/pkt_reg_xactor_chk.sv
module pkt_reg_xactor_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [7:0]        outData,
  input logic              outLast,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busRead,
  input logic              busWrite,
  input logic              busWait
);

  p_rw_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busRead && busWrite));

  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    busRead && busWait |=> busRead && $stable(busAddr));

  p_write_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && busWait |=> busWrite && $stable(busAddr) && $stable(busWrData));

  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  p_no_input_during_access_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busRead || busWrite) |-> !inReady);

  p_no_input_during_reply_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

endmodule

bind pkt_reg_xactor pkt_reg_xactor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inReady   (inReady),
  .outValid  (outValid),
  .outReady  (outReady),
  .outData   (outData),
  .outLast   (outLast),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busRead   (busRead),
  .busWrite  (busWrite),
  .busWait   (busWait)
);

// File: tb/test_pkt_reg_xactor.sv
module test_pkt_reg_xactor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inData = '0;
  logic        inLast = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [7:0]  outData;
  logic        outLast;
  logic [31:0] busAddr;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic        busRead;
  logic        busWrite;
  logic        busWait = 1'b0;

  always #10 clk = ~clk;

  pkt_reg_xactor i_pkt_reg_xactor (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inReady   (inReady),
    .inData    (inData),
    .inLast    (inLast),
    .outValid  (outValid),
    .outReady  (outReady),
    .outData   (outData),
    .outLast   (outLast),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .busRead   (busRead),
    .busWrite  (busWrite),
    .busWait   (busWait)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  logic [31:0] busMem [64];
  logic [31:0] expMem [64];

  logic [8:0]  outQ[$];
  string       outTag[$];
  logic [64:0] busQ[$];
  string       busTag[$];

  logic [7:0] lfsr = 8'hA5;

  assign busRdData = busMem[busAddr[7:2]];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // stall pattern for waitrequest and output ready
  always @(negedge clk) begin
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    busWait  <= lfsr[1] & lfsr[2];
    outReady <= lfsr[0] | lfsr[3];
  end

  // monitor
  logic        stallSeen = 1'b0;
  logic [7:0]  stallData;
  logic        stallLast;
  logic        waitSeen = 1'b0;
  logic [31:0] waitAddr;
  always @(negedge clk) begin
    #5;
    if (rstN) begin
      if (stallSeen)
        check(outValid && outData == stallData && outLast == stallLast, "R11 output hold",
              {55'd0, outValid, outData}, {55'd1, stallData});
      stallSeen = outValid && !outReady;
      stallData = outData;
      stallLast = outLast;

      if (waitSeen)
        check((busRead || busWrite) && busAddr == waitAddr, "R9 access held",
              {31'd0, busRead | busWrite, busAddr}, {31'd1, waitAddr});
      waitSeen = (busRead || busWrite) && busWait;
      waitAddr = busAddr;

      if (outValid && outReady) begin
        if (outQ.size() == 0) begin
          check(1'b0, "R8 unexpected output byte", {55'd0, outLast, outData}, 64'd0);
        end else begin
          logic [8:0] e;
          string t;
          e = outQ.pop_front();
          t = outTag.pop_front();
          check({outLast, outData} == e, t, {55'd0, outLast, outData}, {55'd0, e});
        end
      end

      if ((busRead || busWrite) && !busWait) begin
        if (busQ.size() == 0) begin
          check(1'b0, "R8 unexpected bus access", {31'd0, busWrite, busAddr}, 64'd0);
        end else begin
          logic [64:0] e;
          string t;
          e = busQ.pop_front();
          t = busTag.pop_front();
          if (e[64])
            check(busWrite && busAddr == e[63:32] && busWrData == e[31:0], t,
                  {busAddr, busWrData}, e[63:0]);
          else
            check(busRead && busAddr == e[63:32], t,
                  {31'd0, busRead, busAddr}, {31'd1, e[63:32]});
        end
        if (busWrite) busMem[busAddr[7:2]] = busWrData;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      check(1'b0, "R10 watchdog expired", 64'(cycles), 64'd0);
      finishRun();
    end
  end

  task automatic sendByte(input logic [7:0] b, input logic l);
    @(negedge clk);
    inValid = 1'b1;
    inData  = b;
    inLast  = l;
    #5;
    while (!inReady) begin
      @(negedge clk);
      #5;
    end
  endtask

  task automatic idleIn();
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic sendHeader(input logic [7:0] code, input logic [15:0] cnt,
                            input logic [31:0] addr, input bit lastHere);
    sendByte(code, 1'b0);
    sendByte(8'h00, 1'b0);
    sendByte(cnt[15:8], 1'b0);
    sendByte(cnt[7:0], 1'b0);
    sendByte(addr[31:24], 1'b0);
    sendByte(addr[23:16], 1'b0);
    sendByte(addr[15:8], 1'b0);
    sendByte(addr[7:0], lastHere);
  endtask

  function automatic logic [31:0] wordOf(input logic [31:0] seed, input int k);
    return seed ^ (32'(k) * 32'h9E3779B9);
  endfunction

  task automatic expectOut(input logic [7:0] b, input bit l, input string t);
    outQ.push_back({l, b});
    outTag.push_back(t);
  endtask

  // R1 R2 R3 R4 R5 R6
  task automatic writeReq(input logic [7:0] code, input logic [15:0] cnt,
                          input logic [31:0] addr, input int nData, input logic [31:0] seed);
    int cntI;
    logic [15:0] okCnt;
    cntI = int'(cnt);
    for (int k = 0; (k + 1) * 4 <= nData; k++) begin
      if ((k + 1) * 4 <= cntI) begin
        logic [31:0] a;
        a = addr + 32'(4 * k);
        busQ.push_back({1'b1, a, wordOf(seed, k)});
        busTag.push_back(k == 0 ? "R1 R2 R3 first write" : "R3 R4 sequential write");
        expMem[a[7:2]] = wordOf(seed, k);
      end
    end
    okCnt = (nData == cntI && cnt[1:0] == 2'b00) ? cnt : 16'd0;
    expectOut(code | 8'h80, 1'b0, "R5 write reply code");
    expectOut(8'h00, 1'b0, "R5 write reply spare");
    expectOut(okCnt[15:8], 1'b0, "R6 write reply count high");
    expectOut(okCnt[7:0], 1'b1, "R6 write reply count low");
    sendHeader(code, cnt, addr, nData == 0);
    for (int i = 0; i < nData; i++) begin
      logic [31:0] w;
      w = wordOf(seed, i / 4);
      sendByte(w[8 * (i % 4) +: 8], i == nData - 1);
    end
    idleIn();
  endtask

  // R7 R12
  task automatic readReq(input logic [7:0] code, input logic [15:0] cnt,
                         input logic [31:0] addr, input int nExtra);
    int nw;
    nw = int'(cnt[15:2]);
    if (nw == 0) nw = 1;
    if (nw > 256) nw = 256;
    for (int k = 0; k < nw; k++) begin
      logic [31:0] a;
      logic [31:0] w;
      a = addr + 32'(4 * k);
      w = expMem[a[7:2]];
      busQ.push_back({1'b1 ^ 1'b1, a, 32'd0});
      busTag.push_back(k == 0 ? "R1 R2 first read address" : "R4 R12 read address");
      for (int b = 0; b < 4; b++)
        expectOut(w[8 * b +: 8], (k == nw - 1) && (b == 3), "R7 read data byte");
    end
    sendHeader(code, cnt, addr, nExtra == 0);
    for (int i = 0; i < nExtra; i++)
      sendByte(8'h7A + 8'(i), i == nExtra - 1);
    idleIn();
  endtask

  // R8: nHdr header bytes (1..8) then nData trailing bytes
  task automatic badReq(input logic [7:0] code, input int nHdr, input int nData);
    logic [7:0] hb [8];
    int total;
    hb = '{code, 8'h00, 8'h00, 8'h04, 8'h00, 8'h00, 8'h00, 8'h40};
    total = nHdr + nData;
    expectOut(8'hFF, 1'b0, "R8 error reply byte 0");
    expectOut(8'h00, 1'b0, "R8 error reply byte 1");
    expectOut(8'h00, 1'b0, "R8 error reply byte 2");
    expectOut(8'h00, 1'b1, "R8 error reply byte 3");
    for (int i = 0; i < total; i++)
      sendByte(i < nHdr ? hb[i] : 8'h55, i == total - 1);
    idleIn();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      busMem[i] = 32'h1000_0000 + 32'(i * 32'h0101_0301);
      expMem[i] = 32'h1000_0000 + 32'(i * 32'h0101_0301);
    end
    repeat (3) @(negedge clk);
    #5;
    check(!outValid && !busRead && !busWrite && inReady, "R10 reset state",
          {60'd0, outValid, busRead, busWrite, inReady}, 64'd1);
    @(negedge clk);
    rstN = 1'b1;

    writeReq(8'h00, 16'd4, 32'h0000_0010, 4, 32'hC0DE_7A4A);
    readReq (8'h10, 16'd4, 32'h0000_0010, 0);
    writeReq(8'h04, 16'd16, 32'h0000_0020, 16, 32'h1234_5678);
    readReq (8'h14, 16'd16, 32'h0000_0020, 0);
    writeReq(8'h04, 16'd8, 32'h0000_0080, 12, 32'hAAAA_0001);  // R6 extra data
    writeReq(8'h04, 16'd8, 32'h0000_0090, 5, 32'hBBBB_0002);   // R6 short data
    writeReq(8'h00, 16'd6, 32'h0000_00A0, 6, 32'hCCCC_0003);   // R6 unaligned count
    writeReq(8'h00, 16'd0, 32'h0000_00B0, 0, 32'hDDDD_0004);   // R6 empty
    readReq (8'h14, 16'd24, 32'h0000_0080, 0);
    readReq (8'h10, 16'd0, 32'h0000_0024, 0);                  // R7 zero count
    readReq (8'h14, 16'd12, 32'h0000_0004, 3);                 // R12 trailing bytes
    badReq  (8'h7F, 8, 4);
    badReq  (8'h33, 8, 0);
    badReq  (8'h00, 5, 0);
    badReq  (8'h10, 1, 0);
    readReq (8'h14, 16'd1200, 32'h0000_0100, 0);               // R7 clamp to 256

    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (outQ.size() == 0 && busQ.size() == 0) break;
    end
    repeat (6) @(negedge clk);
    #5;
    check(outQ.size() == 0, "R7 all expected output produced", 64'(outQ.size()), 64'd0);
    check(busQ.size() == 0, "R3 all expected accesses made", 64'(busQ.size()), 64'd0);
    check(!outValid && !busRead && !busWrite && inReady, "R8 idle after traffic",
          {60'd0, outValid, busRead, busWrite, inReady}, 64'd1);
    finishRun();
  end

endmodule